// File: doc/BRIEF.md
# Add-and-Rotate Sequential Multiplier

This block multiplies two unsigned `WIDTH`-bit operands over a fixed number of clock cycles. A one-cycle `start` pulse captures both operands and clears the 2·`WIDTH`-bit product register. The block then runs `WIDTH` iterations, each made of two one-clock phases. In the add phase, multiplier bit `i` gates an addition of the multiplicand into the upper half of the product. In the rotate phase, the whole product register moves one place to the right, and its lowest bit wraps to the top.

The add phase has no spare carry flop. The carry out of the upper-half addition is parked in product bit 0. The accumulation keeps that bit at zero before every add, so it is always free. The following rotation then carries the parked bit into the top position. The rotation is built as two layers of swaps with fixed pairs: 2·`WIDTH`-1 swaps in all, with a depth of two swap stages for any width. When the last rotation completes, the product register holds the full product, `done` pulses and the result stays put until the next start.

Controller states and transitions: `ST_IDLE` → `ST_ADD` on `start`. `ST_ADD` → `ST_ROTATE` always. `ST_ROTATE` → `ST_ADD` while the iteration counter is below `WIDTH`-1. `ST_ROTATE` → `ST_DONE` on the last iteration. `ST_DONE` → `ST_IDLE` always.

Top module: `addrot_mult`

## Requirements
- R1: After reset, `product` is 0 and `busy` and `done` are both 0.
- R2: When `done` is 1, `product` equals `mplier` × `mcand` (unsigned) as captured at the accepted start.
- R3: `done` is 1 for exactly one cycle, and it is first seen 2·`WIDTH` clock edges after the edge that accepts `start`.
- R4: `busy` is 1 for the 2·`WIDTH` cycles between acceptance and `done`, and it is 0 in the cycle `done` is high.
- R5: Raising `start`, or changing `mplier` or `mcand`, while `busy` is 1 does not change the result.
- R6: Once `done` has pulsed, `product` keeps its value until the next accepted `start`.
- R7: Boundary operands: a zero operand gives 0, and two all-ones operands give (2^`WIDTH`-1)².
- R8: In the cycle after an accepted `start`, `product` reads 0, so no earlier result leaks into a new run.
- R9: At the end of rotate phase k (k = 0 … `WIDTH`-1), `product` equals (`mcand` × (`mplier` mod 2^(k+1))) × 2^(`WIDTH`-1-k). Equivalently, each rotation moves every bit one place lower and bit 0 to bit 2·`WIDTH`-1.
- R10: In an add phase whose multiplier bit (bit k of `mplier`, k being the iteration number) is 0, `product` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; accepted only while idle |
| mplier | input | WIDTH | Multiplier operand; its bits gate the additions |
| mcand | input | WIDTH | Multiplicand operand; the value that is added |
| busy | output | 1 | High during the add and rotate phases |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2·WIDTH | Product register; valid when `done` is high and held afterwards |

## Verification
The edge that accepts `start` is counted as edge 0. The cleared product is due one cycle after it. The add result of iteration k is due after edge 2k+1 and the rotated value after edge 2k+2. `done` and the final product are due after edge 2·`WIDTH`, and `done` must fall after the next edge. The bench drives inputs on falling edges and reads each of these values at the falling edge that follows the rising edge it is due on. It predicts every value with plain integer arithmetic: partial sums for R9, equality with the previous phase for R10, and the full product for R2. The sweep covers every operand pair at width 4 and random pairs plus boundaries at width 8.

// File: rtl/addrot_pkg.sv
package addrot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADD,
        ST_ROTATE,
        ST_DONE
    } addrot_state_e;

endpackage

// File: rtl/addrot_ctrl.sv
module addrot_ctrl
    import addrot_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load_op,
    output logic             add_en,
    output logic             rot_en,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIDTH - 1);

    addrot_state_e state_q, state_d;
    logic          last_iter;

    assign last_iter = (idx == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ADD;
            ST_ADD:    state_d = ST_ROTATE;
            ST_ROTATE: state_d = last_iter ? ST_DONE : ST_ADD;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // phase outputs
    always_comb begin
        load_op = 1'b0;
        add_en  = 1'b0;
        rot_en  = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_op = start;
            ST_ADD:    begin add_en = 1'b1; busy = 1'b1; end
            ST_ROTATE: begin rot_en = 1'b1; busy = 1'b1; end
            ST_DONE:   done = 1'b1;
        endcase
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load_op) begin
            idx <= '0;
        end else if (rot_en && !last_iter) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/addrot_cadd.sv
module addrot_cadd #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] addend,
    input  logic             ctl,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] cy;

    assign cy[0] = 1'b0;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic gated;
        logic diff;
        assign gated     = ctl & addend[g];
        assign diff      = acc[g] ^ gated;
        assign sum[g]    = diff ^ cy[g];
        // matching inputs generate their own value; differing ones propagate
        assign cy[g + 1] = diff ? cy[g] : gated;
    end

    assign cout = cy[WIDTH];

endmodule

// File: rtl/addrot_rotnet.sv
module addrot_rotnet #(
    parameter int BITS = 16
) (
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] dout
);

    logic [BITS-1:0] mid;

    // layer one: mirror about position 0 (positions 0 and BITS/2 stay put)
    for (genvar i = 0; i < BITS; i++) begin : g_layer1
        localparam int SRC = (i == 0) ? 0 : BITS - i;
        assign mid[i] = din[SRC];
    end

    // layer two: mirror the whole register end to end
    for (genvar i = 0; i < BITS; i++) begin : g_layer2
        assign dout[i] = mid[BITS - 1 - i];
    end

endmodule

// File: rtl/addrot_mult.sv
module addrot_mult
    import addrot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   mplier,
    input  logic [WIDTH-1:0]   mcand,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW    = 2 * WIDTH;
    localparam int IDX_W = $clog2(WIDTH);

    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic [PW-1:0]    p_q;
    logic [IDX_W-1:0] idx;
    logic             load_op;
    logic             add_en;
    logic             rot_en;
    logic             add_ctl;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic [PW-1:0]    p_rot;

    addrot_ctrl #(
        .WIDTH (WIDTH),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load_op (load_op),
        .add_en  (add_en),
        .rot_en  (rot_en),
        .busy    (busy),
        .done    (done),
        .idx     (idx)
    );

    assign add_ctl = a_q[idx];

    addrot_cadd #(
        .WIDTH (WIDTH)
    ) u_cadd (
        .acc    (p_q[PW-1:WIDTH]),
        .addend (b_q),
        .ctl    (add_ctl),
        .sum    (add_sum),
        .cout   (add_cout)
    );

    addrot_rotnet #(
        .BITS (PW)
    ) u_rotnet (
        .din  (p_q),
        .dout (p_rot)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            p_q <= '0;
        end else if (load_op) begin
            a_q <= mplier;
            b_q <= mcand;
            p_q <= '0;
        end else if (add_en) begin
            p_q[PW-1:WIDTH] <= add_sum;
            // bit 0 is free before every add; it parks the carry until rotation
            if (add_ctl) begin
                p_q[0] <= add_cout;
            end
        end else if (rot_en) begin
            p_q <= p_rot;
        end
    end

    assign product = p_q;

endmodule

// File: rtl/addrot_mult_chk.sv
module addrot_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product,
    input logic               add_en,
    input logic               add_ctl,
    input logic               rot_en
);

    localparam int PW = 2 * WIDTH;

    logic [15:0] run_cnt;
    logic        idle_now;

    assign idle_now = !busy && !done;

    function automatic logic [PW-1:0] rot_right(input logic [PW-1:0] v);
        return {v[0], v[PW-1:1]};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (idle_now && start) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 16'd1;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 16'(PW))); // R3

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy)); // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && start) |=> (busy && product == '0)); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product)); // R6

    AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rot_en |=> (product == rot_right($past(product)))); // R9

    AST_SKIPPED_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !add_ctl) |=> $stable(product)); // R10

endmodule

bind addrot_mult addrot_mult_chk #(
    .WIDTH (WIDTH)
) u_addrot_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product),
    .add_en  (add_en),
    .add_ctl (add_ctl),
    .rot_en  (rot_en)
);

// File: tb/addrot_mult_bench.sv
module addrot_mult_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start4 = 1'b0;
    logic        start8 = 1'b0;
    logic [7:0]  opa = '0;
    logic [7:0]  opb = '0;
    logic        busy4, done4, busy8, done8;
    logic [7:0]  prod4;
    logic [15:0] prod8;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    addrot_mult #(.WIDTH(4)) u_addrot_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start4),
        .mplier  (opa[3:0]),
        .mcand   (opb[3:0]),
        .busy    (busy4),
        .done    (done4),
        .product (prod4)
    );

    addrot_mult #(.WIDTH(8)) u_addrot_mult_w8 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start8),
        .mplier  (opa),
        .mcand   (opb),
        .busy    (busy8),
        .done    (done8),
        .product (prod8)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int get_prod(input bit w8);
        return w8 ? int'(prod8) : int'(prod4);
    endfunction

    function automatic int get_busy(input bit w8);
        return w8 ? int'(busy8) : int'(busy4);
    endfunction

    function automatic int get_done(input bit w8);
        return w8 ? int'(done8) : int'(done4);
    endfunction

    task automatic set_start(input bit w8, input logic v);
        if (w8) start8 = v;
        else    start4 = v;
    endtask

    // one full multiplication; reqf labels the final product check
    task automatic run_op(input bit w8, input int a, input int b,
                          input bit trace, input bit poke, input string reqf);
        int n;
        int prev;
        n = w8 ? 8 : 4;
        opa = 8'(a);
        opb = 8'(b);
        set_start(w8, 1'b1);
        @(negedge clk);              // after the accepting edge (edge 0)
        set_start(w8, 1'b0);
        chk("R8 cleared after start", get_prod(w8), 0);
        chk("R4 busy after start", get_busy(w8), 1);
        prev = get_prod(w8);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);          // after add edge 2k+1
            if (trace && ((a >> k) & 1) == 0)
                chk("R10 skipped add", get_prod(w8), prev);
            if (poke && k == 1) begin
                opa = ~8'(a);
                opb = ~8'(b);
                set_start(w8, 1'b1);
            end
            @(negedge clk);          // after rotate edge 2k+2
            set_start(w8, 1'b0);
            if (trace)
                chk("R9 partial after rotate",
                    get_prod(w8), (b * (a & ((1 << (k + 1)) - 1))) << (n - 1 - k));
            if (k < n - 1) begin
                chk("R3 no early done", get_done(w8), 0);
                chk("R4 busy during run", get_busy(w8), 1);
            end
            prev = get_prod(w8);
        end
        chk("R3 done due", get_done(w8), 1);
        chk("R4 idle at done", get_busy(w8), 0);
        if (poke) chk("R5 start and operands ignored", get_prod(w8), a * b);
        else      chk(reqf, get_prod(w8), a * b);
        @(negedge clk);
        chk("R3 done single cycle", get_done(w8), 0);
        chk("R6 product held", get_prod(w8), a * b);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset product w4", int'(prod4), 0);
        chk("R1 reset product w8", int'(prod8), 0);
        chk("R1 reset busy", int'(busy4) + int'(busy8), 0);
        chk("R1 reset done", int'(done4) + int'(done8), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // width 4: every operand pair
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_op(1'b0, a, b, (a == 11 || a == 5 || b == 15), (b == 7 && a > 0),
                       (a == 0 || b == 0 || (a == 15 && b == 15)) ? "R7 boundary w4" : "R2 product w4");
            end
        end

        // R6: held for several idle cycles with operands moving
        run_op(1'b0, 13, 9, 1'b0, 1'b0, "R2 product w4");
        for (int i = 0; i < 3; i++) begin
            opa = 8'(i * 37 + 1);
            opb = 8'(i * 91 + 5);
            @(negedge clk);
            chk("R6 held while idle", int'(prod4), 117);
        end

        // width 8: boundaries then random pairs
        run_op(1'b1, 0, 255, 1'b1, 1'b0, "R7 zero multiplier w8");
        run_op(1'b1, 255, 0, 1'b1, 1'b0, "R7 zero multiplicand w8");
        run_op(1'b1, 255, 255, 1'b1, 1'b0, "R7 all ones w8");
        run_op(1'b1, 128, 255, 1'b1, 1'b1, "R2 product w8");
        run_op(1'b1, 1, 1, 1'b1, 1'b0, "R2 product w8");
        for (int t = 0; t < 300; t++) begin
            int ra;
            int rb;
            ra = int'($urandom_range(255, 0));
            rb = int'($urandom_range(255, 0));
            run_op(1'b1, ra, rb, (t % 10 == 0), (t % 25 == 3), "R2 product w8");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule